// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital control core of a 14-bit successive-approximation converter. A rising edge on the start pin launches a conversion. On that edge the block looks at the clock-select pin. When the pin is low, conversion clocks come from an internal clock-enable divider. When the pin is high, each rising edge seen later on that same pin counts as one conversion clock. After sixteen conversion clocks the conversion is complete. The result word, supplied by a stub data source on `result_in`, is captured into the output register on the fifteenth conversion clock.

A single status pin reports progress. It is high while a conversion runs. The level of the start pin when the conversion finishes decides what happens next. If start is high, status gives a low pulse one conversion clock long and then returns high. If start is low, status stays low until the next start edge. Tying the start and clock-select pins to one free-running clock therefore produces back-to-back conversions, with a one-clock low pulse between them.

A start edge that arrives during a conversion is ignored and sets a sticky overrun flag. The read side supplies an output-enable for an external tri-state driver of the 14-bit bus. Both pins pass through two-flop synchronisers into the single system-clock domain.

Top module: `adc_seq_core`

## Requirements
- R1: A rising edge on `start_in` passes through a two-flop synchroniser plus an edge flop. `status_o` is high on the third rising `clk` edge after the pin is first sampled high, and not before.
- R2: At the start edge the synchronised `clksel_in` level selects the conversion clock. Low (0) selects one tick every `INT_DIV` system cycles from the internal divider. High (1) selects each later synchronised rising edge of `clksel_in` as a tick, and the divider is then ignored.
- R3: A conversion lasts exactly 16 conversion clocks. With the internal source, `status_o` stays high for exactly 16*`INT_DIV` cycles after the cycle it rises.
- R4: `data_o` takes `result_in` on the 15th conversion clock. A change of `result_in` after that clock does not reach `data_o`, and `data_o` does not change before that clock.
- R5: If synchronised `start_in` is 1 on the 16th clock, `status_o` goes low for exactly one conversion clock, then returns high.
- R6: If synchronised `start_in` is 0 on the 16th clock, `status_o` goes low and stays low until the next start edge.
- R7: With `start_in` and `clksel_in` driven from one clock of period P cycles, conversions repeat with no gap. `status_o` falls once every 17*P cycles and stays low for P cycles each time, and `overrun_o` stays 0.
- R8: A start edge during a conversion does not shorten or restart it and sets `overrun_o` to 1. The flag stays 1 until reset. A start edge that is also the external conversion clock of the running conversion is not an overrun.
- R9: `data_oe_o` is 1 exactly when `cs_n` and `rd_n` are both 0. `data_o` holds the last captured result whatever `cs_n` and `rd_n` do.
- R10: Synchronous active-high `rst` sets `status_o` to 0, `data_o` to 0 and `overrun_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Conversion start pin (asynchronous) |
| clksel_in | input | 1 | Clock-select level at start, then external conversion clock |
| result_in | input | RESULT_W | Result word from the stub data source |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| status_o | output | 1 | Busy / end-of-conversion status |
| data_o | output | RESULT_W | Output data register |
| data_oe_o | output | 1 | Enable for the external tri-state bus driver |
| overrun_o | output | 1 | Sticky flag for a start edge during conversion |

## Verification
The bench builds the block with `RESULT_W` = 14 and `INT_DIV` = 4. A short divider makes an internal conversion 64 cycles long, so many conversions fit in the run, and the exact edge counts for conversion length and pulse width stay small enough to check cycle by cycle. The external clock runs at a period of 6 or 8 cycles. That is slower than the divider, so a conversion that wrongly used the divider would finish before the 14th external edge, and the bench would see it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CONV_CLOCKS = 16;
    localparam int LATCH_CLOCK = 15;
    localparam int CNT_W       = $clog2(CONV_CLOCKS);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CONV = 2'd1,
        SEQ_EOC  = 2'd2
    } seq_st_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } conv_src_e;

    typedef struct packed {
        seq_st_e          st;
        conv_src_e        src;
        logic [CNT_W-1:0] cnt;
    } seq_ctx_t;

    function automatic logic is_latch_clk(input logic [CNT_W-1:0] c);
        return c == CNT_W'(LATCH_CLOCK - 1);
    endfunction

    function automatic logic is_last_clk(input logic [CNT_W-1:0] c);
        return c == CNT_W'(CONV_CLOCKS - 1);
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign level = sh[STAGES-1];
    assign rise  = sh[STAGES-1] & ~sh[STAGES];

    // An edge report lasts one cycle.
    assert_rise_single_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/clk_en_div.sv
module clk_en_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] TOP = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)   cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else                 cnt <= cnt + DIV_W'(1);
    end

    assign tick = (cnt == TOP);

    // With a divide ratio of 2 or more, ticks never come on adjacent cycles.
    generate
        if (DIV > 1) begin : g_chk
            assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (rst)
                (tick && !clear) |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RESULT_W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_rise,
    input  logic                start_lvl,
    input  logic                clksel_lvl,
    input  logic                int_tick,
    input  logic                ext_rise,
    input  logic [RESULT_W-1:0] result_in,
    output logic                div_clear,
    output logic                status_o,
    output logic                overrun_o,
    output logic [RESULT_W-1:0] data_o
);
    seq_ctx_t            ctx;
    logic                status_q;
    logic                err_q;
    logic [RESULT_W-1:0] data_q;
    logic                tick;
    logic                pin_shared;

    assign tick       = (ctx.src == SRC_EXT) ? ext_rise : int_tick;
    assign pin_shared = (ctx.src == SRC_EXT) && ext_rise;
    assign div_clear  = start_rise && (ctx.st != SEQ_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.st   <= SEQ_IDLE;
            ctx.src  <= SRC_INT;
            ctx.cnt  <= '0;
            status_q <= 1'b0;
            err_q    <= 1'b0;
            data_q   <= '0;
        end else begin
            case (ctx.st)
                SEQ_CONV: begin
                    if (start_rise && !pin_shared) err_q <= 1'b1;
                    if (tick) begin
                        if (is_latch_clk(ctx.cnt)) data_q <= result_in;
                        if (is_last_clk(ctx.cnt)) begin
                            ctx.cnt  <= '0;
                            status_q <= 1'b0;
                            ctx.st   <= start_lvl ? SEQ_EOC : SEQ_IDLE;
                        end else begin
                            ctx.cnt <= ctx.cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    if (start_rise) begin
                        ctx.st   <= SEQ_CONV;
                        ctx.src  <= clksel_lvl ? SRC_EXT : SRC_INT;
                        ctx.cnt  <= '0;
                        status_q <= 1'b1;
                    end else if (ctx.st == SEQ_EOC && tick) begin
                        ctx.st   <= SEQ_IDLE;
                        status_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign status_o  = status_q;
    assign overrun_o = err_q;
    assign data_o    = data_q;

    // An accepted start edge raises status and enters conversion.
    assert_start_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (start_rise && ctx.st != SEQ_CONV) |=> (status_q && ctx.st == SEQ_CONV));

    // Status falls only on the 16th conversion clock.
    assert_fall_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_q) && !$past(rst)) |->
            $past(ctx.st == SEQ_CONV && tick && is_last_clk(ctx.cnt)));

    // The output register changes only on the 15th conversion clock.
    assert_latch_point_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(data_q) && !$past(rst)) |->
            $past(ctx.st == SEQ_CONV && tick && is_latch_clk(ctx.cnt)));

    // A start edge during conversion does not disturb the clock count.
    assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (ctx.st == SEQ_CONV && start_rise && !tick) |=>
            (ctx.st == SEQ_CONV && $stable(ctx.cnt)));

    // The overrun flag is sticky.
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
    parameter int RESULT_W = 14,
    parameter int INT_DIV  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_in,
    input  logic                clksel_in,
    input  logic [RESULT_W-1:0] result_in,
    input  logic                cs_n,
    input  logic                rd_n,
    output logic                status_o,
    output logic [RESULT_W-1:0] data_o,
    output logic                data_oe_o,
    output logic                overrun_o
);
    logic start_lvl, start_rise;
    logic clksel_lvl, ext_rise;
    logic int_tick, div_clear;

    sync_edge #(.STAGES(2)) u_start_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (start_in),
        .level (start_lvl),
        .rise  (start_rise)
    );

    sync_edge #(.STAGES(2)) u_clk_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (clksel_in),
        .level (clksel_lvl),
        .rise  (ext_rise)
    );

    clk_en_div #(.DIV(INT_DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (div_clear),
        .tick  (int_tick)
    );

    seq_ctrl #(.RESULT_W(RESULT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_rise (start_rise),
        .start_lvl  (start_lvl),
        .clksel_lvl (clksel_lvl),
        .int_tick   (int_tick),
        .ext_rise   (ext_rise),
        .result_in  (result_in),
        .div_clear  (div_clear),
        .status_o   (status_o),
        .overrun_o  (overrun_o),
        .data_o     (data_o)
    );

    assign data_oe_o = ~cs_n & ~rd_n;

endmodule

// File: tb/sim_adc_seq_core.sv
module sim_adc_seq_core;
    localparam int RW  = 14;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_in = 1'b0;
    logic          clksel_in = 1'b0;
    logic [RW-1:0] result_in = '0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          status_o, data_oe_o, overrun_o;
    logic [RW-1:0] data_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    adc_seq_core #(.RESULT_W(RW), .INT_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .start_in(start_in), .clksel_in(clksel_in),
        .result_in(result_in), .cs_n(cs_n), .rd_n(rd_n),
        .status_o(status_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .overrun_o(overrun_o)
    );

    // bit 14: start held high to the end (1) or dropped early (0); bits 13:0: result word
    localparam logic [14:0] VEC [4] = '{
        15'h5234, 15'h3FFF, 15'h4001, 15'h2AAA
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // count cycles until status equals v
    task automatic until_status(input logic v, output int n);
        n = 0;
        do begin
            cyc(1);
            n++;
        end while (status_o != v && n < 3000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [RW-1:0] prev;

        // R10 reset state
        do_reset();
        chk("R10 status after reset", int'(status_o), 0);
        chk("R10 data after reset", int'(data_o), 0);
        chk("R10 overrun after reset", int'(overrun_o), 0);

        // R9 output enable decode
        for (int c = 0; c < 4; c++) begin
            cs_n = c[0];
            rd_n = c[1];
            #1;
            chk("R9 data_oe decode", int'(data_oe_o), (c == 0) ? 1 : 0);
        end
        cs_n = 1'b1;
        rd_n = 1'b1;

        // R1 start latency
        result_in = 14'h0ABC;
        @(negedge clk);
        start_in = 1'b1;
        cyc(2);
        chk("R1 status before third edge", int'(status_o), 0);
        cyc(1);
        chk("R1 status on third edge", int'(status_o), 1);
        until_status(1'b0, n);
        chk("R3 first conversion length", n, 16 * DIV);
        chk("R4 first result", int'(data_o), 14'h0ABC);
        until_status(1'b1, n);
        chk("R5 first end pulse width", n, DIV);
        start_in = 1'b0;
        cyc(4);

        // vector table: internal-clock conversions in both status modes
        for (int v = 0; v < 4; v++) begin
            result_in = VEC[v][13:0];
            start_in  = 1'b1;
            cyc(3);
            if (!VEC[v][14]) start_in = 1'b0;
            until_status(1'b0, n);
            chk("R3 table conversion length", n, 16 * DIV);
            chk("R4 table result", int'(data_o), int'(VEC[v][13:0]));
            if (VEC[v][14]) begin
                until_status(1'b1, n);
                chk("R5 table end pulse width", n, DIV);
                start_in = 1'b0;
                cyc(4);
            end else begin
                cyc(20);
                chk("R6 status held low", int'(status_o), 0);
            end
        end

        // R9 data held while the read pins move
        prev = data_o;
        cs_n = 1'b0; rd_n = 1'b0; cyc(2);
        cs_n = 1'b1; cyc(2);
        rd_n = 1'b1; cyc(2);
        chk("R9 data held across reads", int'(data_o), int'(prev));

        // R2/R4 external clock, busy ending
        clksel_in = 1'b1;
        cyc(4);
        result_in = 14'h0F0F;
        start_in  = 1'b1;
        cyc(3);
        start_in  = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            clksel_in = 1'b0;
            cyc(3);
            clksel_in = 1'b1;
            cyc(3);
            if (k == 14) begin
                chk("R2 divider ignored in external mode", int'(status_o), 1);
                chk("R4 no capture before 15th clock", int'(data_o), int'(prev));
            end
            if (k == 15) begin
                chk("R4 capture on 15th clock", int'(data_o), 14'h0F0F);
                result_in = 14'h3210;
                chk("R3 still busy after 15 clocks", int'(status_o), 1);
            end
        end
        chk("R6 busy ending after 16 external clocks", int'(status_o), 0);
        chk("R4 late word not captured", int'(data_o), 14'h0F0F);
        clksel_in = 1'b0;
        cyc(6);

        // R8 overrun
        chk("R8 overrun clear before", int'(overrun_o), 0);
        start_in = 1'b1;
        cyc(3);
        start_in = 1'b0;
        n = 0;
        do begin
            cyc(1);
            n++;
            if (n == 20) start_in = 1'b1;
            if (n == 22) start_in = 1'b0;
        end while (status_o != 1'b0 && n < 3000);
        chk("R8 length unchanged by late start", n, 16 * DIV);
        chk("R8 overrun set", int'(overrun_o), 1);
        start_in = 1'b1;
        cyc(3);
        start_in = 1'b0;
        until_status(1'b0, n);
        chk("R8 overrun sticky", int'(overrun_o), 1);
        do_reset();
        chk("R10 overrun cleared by reset", int'(overrun_o), 0);

        // R7 continuous: one pin drives start and clock select
        begin
            logic ps;
            int   fall_at [2];
            int   low_w   [2];
            int   nf, nl, low_from;
            ps = status_o;
            nf = 0; nl = 0; low_from = -1;
            for (int i = 0; i < 600; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (ps && !status_o) begin
                    if (nf < 2) fall_at[nf] = i;
                    nf++;
                    low_from = i;
                end
                if (!ps && status_o && low_from >= 0) begin
                    if (nl < 2) low_w[nl] = i - low_from;
                    nl++;
                    low_from = -1;
                end
                ps = status_o;
                if (i % 4 == 0) begin
                    start_in  = ~start_in;
                    clksel_in = start_in;
                end
            end
            chk("R7 at least two ends seen", int'(nf >= 2), 1);
            chk("R7 first low pulse width", low_w[0], 8);
            chk("R7 second low pulse width", low_w[1], 8);
            chk("R7 spacing of ends", fall_at[1] - fall_at[0], 17 * 8);
            chk("R7 no overrun when tied", int'(overrun_o), 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule